// File: doc/BRIEF.md
# Configurable Output Logic Cell for a Sum-of-Products Device

This block is one output cell of a programmable sum-of-products device. It takes the product terms that the AND array produces for it, ORs them, sets the polarity, and then either registers the result or passes it straight through. It drives a pin value together with a separate active-high tri-state enable, and it returns a feedback bit to the AND array.

Three static configuration bits select the cell's personality: two are shared by every cell of the device and one is local to this cell. The choices are a registered output, a combinational I/O in a device that uses registers, a combinational I/O in a device without registers, a dedicated combinational output, and a dedicated input. A fourth bit, also local, sets the polarity.

The bits steer the multiplexers that choose the product-term routing, the enable source, the output source and the feedback source. A cell at either end of the device takes its feedback-select line from the other global bit. This lets the clock and output-enable pins serve as inputs when the device has no registers.

Top module: `pld_out_cell`

## Requirements
- R1: With cfg_g0=0, cfg_g1=1, cfg_l0=0 (registered), drive_out equals the polarity-adjusted OR of all eight terms captured at the previous rising clk edge, drive_en equals NOT oe_n, and fb_out equals the register value.
- R2: When rst is 1 at a rising clk edge, the register is cleared to 0, so drive_out reads 0 in registered mode after that edge.
- R3: With cfg_g0=0, cfg_g1=1, cfg_l0=1, drive_out is the polarity-adjusted OR of terms 0 to 6 without a clock delay, drive_en equals term 7, and fb_out equals pin_in.
- R4: With cfg_g0=1, cfg_g1=1, cfg_l0=1, drive_out and drive_en behave as in R3, and fb_out equals pin_in on a cell that is not an end cell.
- R5: With cfg_g0=1, cfg_g1=0, cfg_l0=0, drive_out is the polarity-adjusted OR of all eight terms without a clock delay, drive_en is 1, and fb_out equals adj_in.
- R6: With cfg_g0=1, cfg_g1=0, cfg_l0=1 (dedicated input), drive_en is 0 and fb_out equals adj_in.
- R7: cfg_l1=1 gives an active-high output (OR sum as is). cfg_l1=0 inverts the OR sum.
- R8: The combinations {g0,g1,l0} = 000, 001 and 110 force drive_en to 0 and fb_out to 0.
- R9: On an end cell (END_CELL=1) the feedback select uses NOT cfg_g0 in place of cfg_g1. With 111, fb_out equals adj_in. With 010 it equals the register, and with 011 it equals pin_in.
- R10: In both I/O modes, term 7 has no effect on drive_out. It only drives drive_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst | input | 1 | Synchronous active-high register clear |
| pterm | input | NUM_TERMS | Product terms from the AND array; the top index is the enable term |
| oe_n | input | 1 | Global output enable, active low |
| pin_in | input | 1 | Value present at this cell's own pin |
| adj_in | input | 1 | Value present at the neighbouring pin |
| cfg_g0 | input | 1 | Global bit: device does not use registers |
| cfg_g1 | input | 1 | Global bit: device family select |
| cfg_l0 | input | 1 | Local bit: cell personality |
| cfg_l1 | input | 1 | Local bit: 1 active-high, 0 active-low |
| drive_out | output | 1 | Pin data value |
| drive_en | output | 1 | Pin tri-state enable, active high |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
The register is the only state in the cell, and a wrong value in it appears on drive_out and fb_out at the first edge after capture, but only while the registered personality is selected. For that reason the bench samples it immediately after each edge, with reset and with both polarities. Every other path is combinational, so a wrong mode decode or a wrong mux select shows up on drive_en or fb_out in the same cycle as the configuration change. The bench covers all eight configuration codes on a normal cell and on an end cell side by side. This exposes a swapped select line on either cell type at once.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [2:0] {
    MODE_REG_OUT,
    MODE_IO_REGDEV,
    MODE_IO_COMB,
    MODE_COMB_OUT,
    MODE_DED_IN,
    MODE_UNUSED
  } cell_mode_e;

  typedef enum logic [1:0] {
    FB_REG,
    FB_PIN,
    FB_ADJ,
    FB_ZERO
  } fb_src_e;

  // Map the global/local bits onto a personality.
  function automatic cell_mode_e decode_mode(input logic g0, input logic g1, input logic l0);
    cell_mode_e m;
    case ({g0, g1, l0})
      3'b010:  m = MODE_REG_OUT;
      3'b011:  m = MODE_IO_REGDEV;
      3'b111:  m = MODE_IO_COMB;
      3'b100:  m = MODE_COMB_OUT;
      3'b101:  m = MODE_DED_IN;
      default: m = MODE_UNUSED;
    endcase
    return m;
  endfunction

  // XOR stage: active_high=1 keeps the sum, 0 inverts it.
  function automatic logic apply_polarity(input logic sum, input logic active_high);
    return sum ^ ~active_high;
  endfunction

endpackage

// File: rtl/pld_term_router.sv
module pld_term_router #(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] pterm,
  input  logic                 split_oe,
  output logic                 or_sum,
  output logic                 oe_term
);
  localparam int LAST = NUM_TERMS - 1;

  logic sum_all;
  logic sum_less_one;

  assign sum_all      = |pterm;
  assign sum_less_one = |pterm[LAST-1:0];
  assign or_sum       = split_oe ? sum_less_one : sum_all;
  assign oe_term      = pterm[LAST];
endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/pld_cell_select.sv
module pld_cell_select
  import pld_cell_pkg::*;
#(
  parameter bit END_CELL = 1'b0
) (
  input  cell_mode_e mode,
  input  logic       g0,
  input  logic       g1,
  input  logic       l0,
  input  logic       q_val,
  input  logic       pol_val,
  input  logic       oe_term,
  input  logic       oe_n,
  input  logic       pin_in,
  input  logic       adj_in,
  output logic       drive_out,
  output logic       drive_en,
  output logic       fb_out,
  output fb_src_e    fb_src
);
  logic fb_sel_hi;

  generate
    if (END_CELL) begin : g_end
      assign fb_sel_hi = ~g0;
    end else begin : g_mid
      assign fb_sel_hi = g1;
    end
  endgenerate

  always_comb begin
    if (mode == MODE_UNUSED) fb_src = FB_ZERO;
    else if (fb_sel_hi)      fb_src = l0 ? FB_PIN : FB_REG;
    else                     fb_src = FB_ADJ;
  end

  always_comb begin
    case (fb_src)
      FB_REG:  fb_out = q_val;
      FB_PIN:  fb_out = pin_in;
      FB_ADJ:  fb_out = adj_in;
      default: fb_out = 1'b0;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_REG_OUT:                 drive_en = ~oe_n;
      MODE_IO_REGDEV, MODE_IO_COMB: drive_en = oe_term;
      MODE_COMB_OUT:                drive_en = 1'b1;
      default:                      drive_en = 1'b0;
    endcase
  end

  assign drive_out = (mode == MODE_REG_OUT) ? q_val : pol_val;
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8,
  parameter bit END_CELL  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TERMS-1:0] pterm,
  input  logic                 oe_n,
  input  logic                 pin_in,
  input  logic                 adj_in,
  input  logic                 cfg_g0,
  input  logic                 cfg_g1,
  input  logic                 cfg_l0,
  input  logic                 cfg_l1,
  output logic                 drive_out,
  output logic                 drive_en,
  output logic                 fb_out
);
  cell_mode_e mode;
  fb_src_e    fb_src;
  logic       split_oe;
  logic       or_sum;
  logic       oe_term;
  logic       pol_val;
  logic       q_val;

  assign mode     = decode_mode(cfg_g0, cfg_g1, cfg_l0);
  assign split_oe = cfg_g1 & cfg_l0;

  pld_term_router #(.NUM_TERMS(NUM_TERMS)) router_i (
    .pterm    (pterm),
    .split_oe (split_oe),
    .or_sum   (or_sum),
    .oe_term  (oe_term)
  );

  assign pol_val = apply_polarity(or_sum, cfg_l1);

  pld_cell_reg reg_i (
    .clk (clk),
    .rst (rst),
    .d   (pol_val),
    .q   (q_val)
  );

  pld_cell_select #(.END_CELL(END_CELL)) sel_i (
    .mode      (mode),
    .g0        (cfg_g0),
    .g1        (cfg_g1),
    .l0        (cfg_l0),
    .q_val     (q_val),
    .pol_val   (pol_val),
    .oe_term   (oe_term),
    .oe_n      (oe_n),
    .pin_in    (pin_in),
    .adj_in    (adj_in),
    .drive_out (drive_out),
    .drive_en  (drive_en),
    .fb_out    (fb_out),
    .fb_src    (fb_src)
  );
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
  parameter int NUM_TERMS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_TERMS-1:0] pterm,
  input logic                 oe_n,
  input logic                 cfg_g0,
  input logic                 cfg_g1,
  input logic                 cfg_l0,
  input logic                 drive_out,
  input logic                 drive_en,
  input logic                 fb_out,
  input logic                 pol_val,
  input logic                 q_val
);
  logic reg_mode, io_mode, comb_mode, din_mode, bad_mode;

  assign reg_mode  = !cfg_g0 && cfg_g1 && !cfg_l0;
  assign io_mode   = cfg_g1 && cfg_l0;
  assign comb_mode = cfg_g0 && !cfg_g1 && !cfg_l0;
  assign din_mode  = cfg_g0 && !cfg_g1 && cfg_l0;
  assign bad_mode  = !(reg_mode || io_mode || comb_mode || din_mode);

  assert_reg_capture_R1: assert property (@(posedge clk) disable iff (rst)
    reg_mode |=> (!reg_mode || drive_out == $past(pol_val)));

  assert_reg_enable_R1: assert property (@(posedge clk) disable iff (rst)
    reg_mode |-> (drive_en == !oe_n));

  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q_val == 1'b0));

  assert_io_enable_R3: assert property (@(posedge clk) disable iff (rst)
    io_mode |-> (drive_en == pterm[NUM_TERMS-1]));

  assert_comb_enable_R5: assert property (@(posedge clk) disable iff (rst)
    comb_mode |-> drive_en);

  assert_input_off_R6: assert property (@(posedge clk) disable iff (rst)
    din_mode |-> !drive_en);

  assert_unused_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> (!drive_en && !fb_out));
endmodule

bind pld_out_cell pld_out_cell_chk #(.NUM_TERMS(NUM_TERMS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .pterm     (pterm),
  .oe_n      (oe_n),
  .cfg_g0    (cfg_g0),
  .cfg_g1    (cfg_g1),
  .cfg_l0    (cfg_l0),
  .drive_out (drive_out),
  .drive_en  (drive_en),
  .fb_out    (fb_out),
  .pol_val   (pol_val),
  .q_val     (q_val)
);

// File: tb/pld_out_cell_tb_top.sv
module pld_out_cell_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pterm = '0;
  logic       oe_n = 1'b1;
  logic       pin_in = 1'b0;
  logic       adj_in = 1'b0;
  logic       g0 = 1'b0, g1 = 1'b0, l0 = 1'b0, l1 = 1'b0;
  logic       out_m, en_m, fb_m;
  logic       out_e, en_e, fb_e;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    string tag;
    bit    chk_out;
    logic  out_x;
    logic  en_x;
    logic  fb_mid_x;
    logic  fb_end_x;
  } exp_t;

  exp_t sb[$];
  logic q_model = 1'b0;

  always #2.5 clk = ~clk;

  pld_out_cell #(.NUM_TERMS(8), .END_CELL(1'b0)) dut_i (
    .clk(clk), .rst(rst), .pterm(pterm), .oe_n(oe_n), .pin_in(pin_in), .adj_in(adj_in),
    .cfg_g0(g0), .cfg_g1(g1), .cfg_l0(l0), .cfg_l1(l1),
    .drive_out(out_m), .drive_en(en_m), .fb_out(fb_m));

  pld_out_cell #(.NUM_TERMS(8), .END_CELL(1'b1)) dut_end_i (
    .clk(clk), .rst(rst), .pterm(pterm), .oe_n(oe_n), .pin_in(pin_in), .adj_in(adj_in),
    .cfg_g0(g0), .cfg_g1(g1), .cfg_l0(l0), .cfg_l1(l1),
    .drive_out(out_e), .drive_en(en_e), .fb_out(fb_e));

  function automatic logic polar(input logic s, input logic hi);
    return hi ? s : !s;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: apply one stimulus at the falling edge and push its expectation.
  task automatic step(input string tag, input logic r, input logic [2:0] cfg, input logic pol,
                      input logic [7:0] t, input logic oen, input logic pin, input logic adj);
    exp_t e;
    logic s8, s7;
    @(negedge clk);
    rst = r; {g0, g1, l0} = cfg; l1 = pol; pterm = t; oe_n = oen; pin_in = pin; adj_in = adj;
    s8 = |t;
    s7 = |t[6:0];
    e.tag = tag;
    e.chk_out = 1'b1;
    e.out_x = 1'b0;
    if (cfg == 3'b010) q_model = r ? 1'b0 : polar(s8, pol);
    case (cfg)
      3'b010: begin e.out_x = q_model; e.en_x = !oen; e.fb_mid_x = q_model; e.fb_end_x = q_model; end
      3'b011: begin e.out_x = polar(s7, pol); e.en_x = t[7]; e.fb_mid_x = pin; e.fb_end_x = pin; end
      3'b111: begin e.out_x = polar(s7, pol); e.en_x = t[7]; e.fb_mid_x = pin; e.fb_end_x = adj; end
      3'b100: begin e.out_x = polar(s8, pol); e.en_x = 1'b1; e.fb_mid_x = adj; e.fb_end_x = adj; end
      3'b101: begin e.chk_out = 1'b0; e.en_x = 1'b0; e.fb_mid_x = adj; e.fb_end_x = adj; end
      default: begin e.chk_out = 1'b0; e.en_x = 1'b0; e.fb_mid_x = 1'b0; e.fb_end_x = 1'b0; end
    endcase
    sb.push_back(e);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.chk_out) begin
          check(e.tag, "out", out_m, e.out_x);
          check(e.tag, "out_end", out_e, e.out_x);
        end
        check(e.tag, "en", en_m, e.en_x);
        check(e.tag, "en_end", en_e, e.en_x);
        check(e.tag, "fb", fb_m, e.fb_mid_x);
        check(e.tag, "fb_end", fb_e, e.fb_end_x);
      end
    end
  end

  initial begin
    logic [7:0] pats [6];
    pats = '{8'h00, 8'h01, 8'h80, 8'h40, 8'hFF, 8'h81};
    // R2: reset clears the register even with all terms high
    step("R2", 1'b1, 3'b010, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    step("R2", 1'b1, 3'b010, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1);
    // R1 / R7: registered personality, both polarities and both enables
    for (int i = 0; i < 6; i++) begin
      step("R1", 1'b0, 3'b010, 1'b1, pats[i], i[0], i[1], !i[1]);
      step("R7", 1'b0, 3'b010, 1'b0, pats[i], !i[0], i[1], i[0]);
    end
    step("R2", 1'b1, 3'b010, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
    // R3 / R4 / R10 / R9: I/O personalities
    for (int i = 0; i < 6; i++) begin
      step("R3", 1'b0, 3'b011, i[0], pats[i], 1'b0, i[1], !i[1]);
      step("R4", 1'b0, 3'b111, !i[0], pats[i], 1'b1, !i[1], i[1]);
    end
    step("R10", 1'b0, 3'b011, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0);
    step("R10", 1'b0, 3'b111, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0);
    step("R9", 1'b0, 3'b111, 1'b1, 8'h02, 1'b0, 1'b0, 1'b1);
    step("R9", 1'b0, 3'b111, 1'b1, 8'h02, 1'b0, 1'b1, 1'b0);
    step("R9", 1'b0, 3'b011, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
    step("R9", 1'b0, 3'b010, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    // R5 / R6: dedicated output and dedicated input
    for (int i = 0; i < 6; i++) begin
      step("R5", 1'b0, 3'b100, i[0], pats[i], 1'b1, !i[0], i[1]);
      step("R6", 1'b0, 3'b101, i[0], pats[i], 1'b0, i[1], !i[0]);
    end
    // R8: unused codes silence enable and feedback
    step("R8", 1'b0, 3'b000, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1);
    step("R8", 1'b0, 3'b001, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1);
    step("R8", 1'b0, 3'b110, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1);
    step("R8", 1'b0, 3'b010, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
    wait (sb.size() == 0);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule